// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block is the register front end of a fuse array that can be written only once. The array holds up to 1024 bytes. Software sees a 32-bit register window. It writes a byte address and a bit position, then issues commands. One command copies the addressed fuse byte into a data register. Another sets the addressed fuse bit, and it runs only after a fixed two-word unlock pair has been written. A fuse bit that has been set can never be cleared. A status register reports when an operation has finished.

A configuration word carries a disable flag and a row of lock flags. Both are sticky. Each lock flag freezes one read-lock bit and one program-lock bit in the same word. Two resets drive the block. `por_n` is the power-on reset and clears everything, fuses included. `rst_n` clears only the registers, so the fuse contents survive it.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x00 status, 0x04 address, 0x08 data, 0x0C configuration and 0x14 command. A read of any other offset, or of an address whose two low bits are not zero, returns 0. A write to any of those addresses changes nothing. `bus_rdata` is 0 whenever a read is not being presented.
- R2: After either reset is released, status reads 0x00000001, configuration reads 0x20000000, and address, data and command read 0. `rst_n` leaves the fuse contents unchanged. `por_n` clears every fuse byte to 0.
- R3: In the status register, bit 0 is ready and bit 1 is done; software cannot set either one. Writing 1 to bit 1 clears done. Writing 0 to bit 1 leaves done unchanged. Bit 2 is an interrupt-enable flag that software can read and write. Bits 31:3 read 0.
- R4: The address register stores bits 12:0 of the written word and reads bits 31:13 as 0. Bits 9:0 select the fuse byte and bits 12:10 select the bit within that byte.
- R5: Writing 0x00000002 to the command register loads the addressed fuse byte into data bits 7:0, with data bits 31:8 read as 0. The same write sets ready and done.
- R6: A program operation runs only when 0xBF79E5D0 is written to the command register and the command write just before it was 0x00000001. Writes to other registers in between do not break the pair. A program operation sets ready and done.
- R7: A program operation sets exactly the addressed fuse bit to 1. It never clears a fuse bit, and programming a bit that is already set changes nothing.
- R8: The command register always reads 0. It keeps the armed state only when 0x00000001 is written; any other command write disarms it.
- R9: The data register is cleared to 0 only by a write of 0x00000001. A write of any other value to it is ignored.
- R10: Configuration bit 31 (disable) and bits 23:16 (lock) are sticky. Writing 1 sets them and nothing clears them except reset.
- R11: While configuration lock bit 16+n is set, bits n and 8+n of the configuration register keep their value across writes, for n from 0 to 7.
- R12: Every configuration bit that is neither sticky nor frozen takes the written value. This includes bits 30:24 and bit 29, which resets to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset; clears the registers and the fuse array |
| rst_n | input | 1 | Active-low register reset; fuse array untouched |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |

## Verification
The bench sweeps all 1024 fuse bytes, programming one bit at a time and reading every byte back against a bench-side array. A design that decoded the bit position or byte index wrongly, or that cleared fuse bits, fails the byte-by-byte comparison.

The unlock pair is attacked several ways:
- the fire word written without arming;
- a read command placed between the two words;
- a second fire word written after a completed program.

A design that tracked the pair loosely would program a fuse in one of these cases.

A pseudo-random run of configuration writes is compared against an arithmetic model of the sticky and frozen bits. Getting the lock mask wrong lets a frozen bit move, or lets a sticky bit fall.

A register-only reset is checked to keep fuse contents, and a power-on reset is checked to clear them.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

    // word indexes inside the register window
    localparam int unsigned WIDX_STAT = 0;
    localparam int unsigned WIDX_ADDR = 1;
    localparam int unsigned WIDX_DATA = 2;
    localparam int unsigned WIDX_CFG  = 3;
    localparam int unsigned WIDX_CMD  = 5;

    localparam logic [31:0] CMD_READ   = 32'h0000_0002;
    localparam logic [31:0] CMD_ARM    = 32'h0000_0001;
    localparam logic [31:0] CMD_FIRE   = 32'hBF79_E5D0;
    localparam logic [31:0] DATA_CLEAR = 32'h0000_0001;

    localparam logic [31:0] CFG_RESET  = 32'h2000_0000;
    localparam logic [31:0] CFG_STICKY = 32'h80FF_0000;

    localparam int unsigned FA_ADDR_W = 13;
    localparam int unsigned FA_BYTE_W = 10;

    typedef struct packed {
        logic ien;
        logic done;
        logic rdy;
    } stat_t;

    localparam stat_t STAT_RESET = '{ien: 1'b0, done: 1'b0, rdy: 1'b1};

    typedef struct packed {
        stat_t                st;
        logic [FA_ADDR_W-1:0] addr;
        logic [7:0]           data;
    } ctl_regs_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_ADDR,
        SEL_DATA,
        SEL_CFG,
        SEL_CMD
    } reg_sel_e;

endpackage

// File: rtl/otp_cfg_lock.sv
module otp_cfg_lock
    import otp_fuse_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] cfg_o
);

    logic [31:0] cfg_d, cfg_q;
    logic [31:0] freeze;

    always_comb begin
        freeze = {16'h0000, cfg_q[23:16], cfg_q[23:16]};
        cfg_d  = cfg_q;
        if (wr_en_i) begin
            cfg_d = (cfg_q & CFG_STICKY) | (cfg_q & freeze) | (wdata_i & ~freeze);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_q & $past(cfg_q) & CFG_STICKY) == ($past(cfg_q) & CFG_STICKY)));

    for (genvar n = 0; n < 8; n++) begin : g_lock
        // R11
        lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(cfg_q[16+n]) |-> (cfg_q[n] == $past(cfg_q[n]) &&
                                    cfg_q[8+n] == $past(cfg_q[8+n])));
    end

endmodule

// File: rtl/otp_cmd_seq.sv
module otp_cmd_seq
    import otp_fuse_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic [31:0] wdata_i,
    output logic        rd_op_o,
    output logic        prog_op_o
);

    logic armed_d, armed_q;

    always_comb begin
        rd_op_o   = wr_en_i && (wdata_i == CMD_READ);
        prog_op_o = wr_en_i && (wdata_i == CMD_FIRE) && armed_q;
        armed_d   = armed_q;
        if (wr_en_i) armed_d = (wdata_i == CMD_ARM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end

    // R6
    fire_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_op_o |=> !armed_q);

    // R8
    arm_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wdata_i != CMD_ARM) |=> !armed_q);

endmodule

// File: rtl/otp_fuse_store.sv
module otp_fuse_store #(
    parameter int unsigned ARRAY_BYTES = 1024,
    parameter int unsigned IDX_W       = $clog2(ARRAY_BYTES)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [2:0]       bit_i,
    input  logic             prog_i,
    output logic [7:0]       rd_byte_o
);

    logic [7:0] mem_q [ARRAY_BYTES];
    logic [7:0] mem_d [ARRAY_BYTES];

    always_comb begin
        mem_d = mem_q;
        if (prog_i) mem_d[idx_i][bit_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int i = 0; i < ARRAY_BYTES; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_byte_o = mem_q[idx_i];

    // R7
    one_way_chk: assert property (@(posedge clk) disable iff (!por_n)
        $stable(idx_i) |-> ((rd_byte_o & $past(rd_byte_o)) == $past(rd_byte_o)));

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otp_fuse_pkg::*;
#(
    parameter int unsigned BUS_AW      = 12,
    parameter int unsigned ARRAY_BYTES = 1024
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam int unsigned IDX_W = $clog2(ARRAY_BYTES);
    localparam int unsigned WW    = BUS_AW - 2;

    logic      regs_rst_n;
    ctl_regs_t regs_d, regs_q;
    reg_sel_e  sel;
    logic      wr_stat, wr_addr, wr_data, wr_cfg, wr_cmd;
    logic      rd_op, prog_op;
    logic [7:0]  fuse_byte;
    logic [31:0] cfg;
    logic [31:0] rmux;

    assign regs_rst_n = rst_n && por_n;

    always_comb begin
        sel = SEL_NONE;
        if (bus_sel && bus_addr[1:0] == 2'b00) begin
            case (bus_addr[BUS_AW-1:2])
                WW'(WIDX_STAT): sel = SEL_STAT;
                WW'(WIDX_ADDR): sel = SEL_ADDR;
                WW'(WIDX_DATA): sel = SEL_DATA;
                WW'(WIDX_CFG):  sel = SEL_CFG;
                WW'(WIDX_CMD):  sel = SEL_CMD;
                default:        sel = SEL_NONE;
            endcase
        end
        wr_stat = bus_wr && sel == SEL_STAT;
        wr_addr = bus_wr && sel == SEL_ADDR;
        wr_data = bus_wr && sel == SEL_DATA;
        wr_cfg  = bus_wr && sel == SEL_CFG;
        wr_cmd  = bus_wr && sel == SEL_CMD;
    end

    otp_cmd_seq u_cmd (
        .clk       (clk),
        .rst_n     (regs_rst_n),
        .wr_en_i   (wr_cmd),
        .wdata_i   (bus_wdata),
        .rd_op_o   (rd_op),
        .prog_op_o (prog_op)
    );

    otp_cfg_lock u_cfg (
        .clk     (clk),
        .rst_n   (regs_rst_n),
        .wr_en_i (wr_cfg),
        .wdata_i (bus_wdata),
        .cfg_o   (cfg)
    );

    otp_fuse_store #(.ARRAY_BYTES(ARRAY_BYTES), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .por_n     (por_n),
        .idx_i     (regs_q.addr[IDX_W-1:0]),
        .bit_i     (regs_q.addr[FA_BYTE_W+2:FA_BYTE_W]),
        .prog_i    (prog_op),
        .rd_byte_o (fuse_byte)
    );

    always_comb begin
        regs_d = regs_q;
        if (rd_op || prog_op) begin
            regs_d.st.rdy  = 1'b1;
            regs_d.st.done = 1'b1;
        end
        if (rd_op) regs_d.data = fuse_byte;
        if (wr_stat) begin
            regs_d.st.ien = bus_wdata[2];
            if (bus_wdata[1]) regs_d.st.done = 1'b0;
        end
        if (wr_addr) regs_d.addr = bus_wdata[FA_ADDR_W-1:0];
        if (wr_data && bus_wdata == DATA_CLEAR) regs_d.data = '0;
    end

    always_ff @(posedge clk or negedge regs_rst_n) begin
        if (!regs_rst_n) regs_q <= '{st: STAT_RESET, addr: '0, data: '0};
        else             regs_q <= regs_d;
    end

    always_comb begin
        case (sel)
            SEL_STAT: rmux = {29'd0, regs_q.st};
            SEL_ADDR: rmux = {{(32-FA_ADDR_W){1'b0}}, regs_q.addr};
            SEL_DATA: rmux = {24'd0, regs_q.data};
            SEL_CFG:  rmux = cfg;
            default:  rmux = '0;
        endcase
        bus_rdata = (bus_sel && !bus_wr) ? rmux : 32'd0;
    end

    // R1
    bad_write_chk: assert property (@(posedge clk) disable iff (!regs_rst_n)
        (bus_sel && bus_wr && bus_addr[1:0] != 2'b00) |=>
            (regs_q == $past(regs_q) && cfg == $past(cfg)));

    // R5
    read_load_chk: assert property (@(posedge clk) disable iff (!regs_rst_n)
        rd_op |=> (regs_q.st.done && regs_q.data == $past(fuse_byte)));

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!regs_rst_n)
        (wr_data && bus_wdata != DATA_CLEAR) |=> $stable(regs_q.data));

    // R3
    done_clear_chk: assert property (@(posedge clk) disable iff (!regs_rst_n)
        (wr_stat && bus_wdata[1]) |=> !regs_q.st.done);

endmodule

// File: tb/tb_otp_fuse_ctrl.sv
`timescale 1ns/1ps
module tb_otp_fuse_ctrl;

    localparam logic [11:0] A_STAT = 12'h000, A_ADDR = 12'h004, A_DATA = 12'h008,
                            A_CFG = 12'h00C, A_CMD = 12'h014;
    localparam logic [31:0] ARM = 32'h1, FIRE = 32'hBF79E5D0, RDC = 32'h2;

    logic        clk = 0, por_n = 0, rst_n = 0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [7:0]  mdl [1024];
    logic [31:0] mcfg;

    always #4 clk = ~clk;

    otp_fuse_ctrl dut (.clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic prog(input int idx, input int b);
        wr(A_ADDR, {19'd0, 3'(b), 10'(idx)});
        wr(A_CMD, ARM);
        wr(A_CMD, FIRE);
    endtask

    task automatic fetch(input int idx);
        wr(A_ADDR, {22'd0, 10'(idx)});
        wr(A_CMD, RDC);
    endtask

    function automatic logic [31:0] cfg_model(input logic [31:0] cur, input logic [31:0] w);
        logic [31:0] fr;
        fr = {16'h0, cur[23:16], cur[23:16]};
        return (cur & 32'h80FF0000) | (cur & fr) | (w & ~fr);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] lcg, w;
        for (int i = 0; i < 1024; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        por_n = 1; rst_n = 1;

        // R2 reset values
        rd_chk("R2 stat", A_STAT, 32'h1);
        rd_chk("R2 cfg", A_CFG, 32'h2000_0000);
        rd_chk("R2 addr", A_ADDR, 0);
        rd_chk("R2 data", A_DATA, 0);
        rd_chk("R8 cmd", A_CMD, 0);

        // R1 unmapped and misaligned
        rd_chk("R1 0x10", 12'h010, 0);
        rd_chk("R1 0x18", 12'h018, 0);
        rd_chk("R1 0xFFC", 12'hFFC, 0);
        rd_chk("R1 misaligned", 12'h00D, 0);
        wr(12'h00D, 32'hFFFF_FFFF);
        wr(12'h006, 32'hFFFF_FFFF);
        wr(12'h010, 32'hFFFF_FFFF);
        rd_chk("R1 cfg untouched", A_CFG, 32'h2000_0000);
        rd_chk("R1 addr untouched", A_ADDR, 0);
        check("R1 idle rdata", bus_rdata, 0);

        // R4 address field width
        wr(A_ADDR, 32'hFFFF_FFFF);
        rd_chk("R4 addr", A_ADDR, 32'h1FFF);

        // R5 read sweep of a fresh array
        for (int i = 0; i < 1024; i++) begin
            fetch(i);
            rd_chk("R5 fresh byte", A_DATA, 0);
        end
        rd_chk("R5 status", A_STAT, 32'h3);
        wr(A_STAT, 32'h2);
        rd_chk("R3 done cleared", A_STAT, 32'h1);

        // R7 program sweep
        for (int i = 0; i < 1024; i++) begin
            prog(i, i % 8);
            mdl[i][i % 8] = 1'b1;
            if (i % 3 == 0) begin
                prog(i, (i * 5 + 3) % 8);
                mdl[i][(i * 5 + 3) % 8] = 1'b1;
            end
        end
        rd_chk("R6 status after program", A_STAT, 32'h3);
        for (int i = 0; i < 1024; i++) begin
            fetch(i);
            rd_chk("R7 byte", A_DATA, {24'd0, mdl[i]});
        end

        // R7 reprogram a set bit
        prog(7, 7);
        fetch(7);
        rd_chk("R7 reprogram", A_DATA, {24'd0, mdl[7]});

        // R6 sequence corner cases on byte 8 (model 0x01)
        wr(A_ADDR, {19'd0, 3'd6, 10'd8});
        wr(A_CMD, FIRE);
        wr(A_CMD, ARM); wr(A_CMD, RDC); wr(A_CMD, FIRE);
        fetch(8);
        rd_chk("R6 no arm", A_DATA, {24'd0, mdl[8]});
        wr(A_ADDR, {19'd0, 3'd6, 10'd8});
        wr(A_CMD, ARM); wr(A_CMD, ARM); wr(A_CMD, FIRE);
        mdl[8][6] = 1'b1;
        wr(A_ADDR, {19'd0, 3'd4, 10'd8});
        wr(A_CMD, FIRE);
        fetch(8);
        rd_chk("R6 double arm then refire", A_DATA, {24'd0, mdl[8]});
        wr(A_CMD, ARM);
        wr(A_ADDR, {19'd0, 3'd2, 10'd8});
        wr(A_CMD, FIRE);
        mdl[8][2] = 1'b1;
        fetch(8);
        rd_chk("R6 addr write between", A_DATA, {24'd0, mdl[8]});

        // R8 command reads zero when armed
        wr(A_CMD, ARM);
        rd_chk("R8 cmd armed", A_CMD, 0);
        wr(A_CMD, 32'h0);

        // R9 data register
        fetch(8);
        wr(A_DATA, 32'h5);
        rd_chk("R9 ignore 5", A_DATA, {24'd0, mdl[8]});
        wr(A_DATA, 32'hFFFF_FFFF);
        rd_chk("R9 ignore ones", A_DATA, {24'd0, mdl[8]});
        wr(A_DATA, 32'h1);
        rd_chk("R9 clear", A_DATA, 0);

        // R3 status bits
        wr(A_STAT, 32'hFFFF_FFFF);
        rd_chk("R3 ien set done clr", A_STAT, 32'h5);
        wr(A_STAT, 32'h0);
        rd_chk("R3 ien clr rdy kept", A_STAT, 32'h1);
        fetch(0);
        wr(A_STAT, 32'h0);
        rd_chk("R3 zero keeps done", A_STAT, 32'h3);

        // R10 R11 R12 configuration
        mcfg = 32'h2000_0000;
        wr(A_CFG, 32'h0);
        mcfg = cfg_model(mcfg, 32'h0);
        rd_chk("R12 bit29 writable", A_CFG, mcfg);
        wr(A_CFG, 32'h7F00_FFFF);
        mcfg = cfg_model(mcfg, 32'h7F00_FFFF);
        rd_chk("R12 open bits", A_CFG, mcfg);
        wr(A_CFG, 32'h7F01_FFFF);
        mcfg = cfg_model(mcfg, 32'h7F01_FFFF);
        wr(A_CFG, 32'h0);
        mcfg = cfg_model(mcfg, 32'h0);
        rd_chk("R11 lock0 freezes bits 0 and 8", A_CFG, mcfg);
        lcg = 32'h1234_5678;
        for (int k = 0; k < 48; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            w = lcg;
            if (k % 4 != 3) w[31] = 1'b0;
            if (k % 2 == 0) w[23:16] = w[23:16] & w[15:8] & 8'h5A;
            wr(A_CFG, w);
            mcfg = cfg_model(mcfg, w);
            rd_chk("R10 R11 R12 cfg sweep", A_CFG, mcfg);
        end
        wr(A_CFG, 32'h0);
        mcfg = cfg_model(mcfg, 32'h0);
        rd_chk("R10 sticky after zero", A_CFG, mcfg);

        // R2 register reset keeps fuses, power-on reset clears them
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd_chk("R2 cfg after rst", A_CFG, 32'h2000_0000);
        rd_chk("R2 stat after rst", A_STAT, 32'h1);
        fetch(8);
        rd_chk("R2 fuse kept", A_DATA, {24'd0, mdl[8]});
        @(negedge clk); por_n = 0;
        @(negedge clk); por_n = 1;
        fetch(8);
        rd_chk("R2 fuse cleared by por", A_DATA, 0);
        fetch(1023);
        rd_chk("R2 last fuse cleared", A_DATA, 0);

        finish_run();
    end

endmodule